// File: doc/BRIEF.md
# Host Configuration Write Port

This block lets a small microcontroller set the mode and per-channel configuration of a chip over a narrow multiplexed bus. Seven shared lines first carry a register address, which is captured when the address strobe falls. The same lines then carry the data, which is taken when the active-low write strobe returns high while the chip is selected. The block only acts while its enable input is high. Otherwise the chip takes its configuration from dedicated pins, and this port leaves its registers untouched.

All host pins are asynchronous to the core clock. They pass through a two-stage synchronizer. Strobe edges are found by comparing the synchronized level with the level one cycle earlier. An accepted write produces a one-cycle commit request, and the register bank applies it on the next edge. The port has no read path and never drives the bus. Its only outputs are the register contents, laid out flat for the rest of the chip.

Top module: `hcfg_port`

## Requirements
- R1: After reset every configuration register reads zero on `cfg_o`.
- R2: Register `k` occupies bits `[7k+6:7k]` of `cfg_o`. Its address is the value on `ad` when `ale` falls. The value on `ad` when `wr_n` rises, with `cs` high, becomes its new contents.
- R3: With pins changed between clock edges, a register update appears on `cfg_o` at the fourth rising clock edge after `wr_n` goes high, and not at the third.
- R4: A write strobe that rises while `cs` is low changes no register.
- R5: While `host_en` is low, address strobes and write strobes have no effect. Any address captured before `host_en` went low is discarded.
- R6: A write to an address of `NREG` or above is ignored, and all registers keep their values.
- R7: A write strobe with no address captured since the previous write strobe changes nothing. Each captured address serves exactly one write strobe.
- R8: A write changes only the addressed register.
- R9: When `ale` falls twice before a write, the later address is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | High enables the host port |
| ale | input | 1 | Address strobe; its falling edge captures `ad` as the address |
| wr_n | input | 1 | Active-low write strobe; its rising edge takes `ad` as data |
| cs | input | 1 | Chip select, high for this device |
| ad | input | 7 | Shared address/data lines (never driven) |
| cfg_o | output | NREG*7 | Register contents, register k at bits [7k+6:7k] |

## Verification
A corrupted captured address, or a captured address that is never consumed, shows up on `cfg_o` four clock edges after the write strobe. The data lands in the wrong slot, or it lands in a slot where it should have been dropped. Every write is therefore followed by a comparison of the whole output vector against a model. A stuck or missing synchronizer stage shifts the update by one edge, which the exact-latency check exposes. A wrong enable or select gate leaves the vector changed after a write that should have been ignored.

// File: rtl/hcfg_pkg.sv
package hcfg_pkg;

    // Width of the shared address/data lines.
    localparam int BUS_W = 7;

    typedef logic [BUS_W-1:0] bus_t;

    // Host pins as one bundle so they share a synchronizer.
    typedef struct packed {
        logic en;
        logic ale;
        logic wr_n;
        logic cs;
        bus_t ad;
    } host_pins_t;

    // Idle bus: strobes inactive, write strobe high.
    localparam host_pins_t PINS_IDLE = '{en: 1'b0, ale: 1'b0, wr_n: 1'b1, cs: 1'b0, ad: '0};

    // One-cycle commit request towards the register bank.
    typedef struct packed {
        logic vld;
        bus_t addr;
        bus_t data;
    } wr_req_t;

    localparam wr_req_t REQ_NONE = '{vld: 1'b0, addr: '0, data: '0};

    function automatic logic fell_edge(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

    function automatic logic rose_edge(input logic prev, input logic cur);
        return ~prev & cur;
    endfunction

endpackage

// File: rtl/hcfg_sync.sv
module hcfg_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    // Flop chain; stage 0 samples the asynchronous pins.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= RST_VAL;
                else     stage_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= RST_VAL;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/hcfg_strobe.sv
module hcfg_strobe
    import hcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  host_pins_t pins_i,
    output wr_req_t    req_o
);

    // Previous synchronized strobe levels, for edge detection.
    logic    ale_prev_q;
    logic    wrn_prev_q;
    bus_t    addr_q;
    logic    addr_vld_q;
    wr_req_t req_q;

    logic ale_fall;
    logic wr_rise;
    logic wr_accept;

    always_comb begin
        ale_fall  = fell_edge(ale_prev_q, pins_i.ale);
        wr_rise   = rose_edge(wrn_prev_q, pins_i.wr_n);
        wr_accept = pins_i.en && wr_rise && pins_i.cs && addr_vld_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_prev_q <= PINS_IDLE.ale;
            wrn_prev_q <= PINS_IDLE.wr_n;
            addr_q     <= '0;
            addr_vld_q <= 1'b0;
            req_q      <= REQ_NONE;
        end else begin
            ale_prev_q <= pins_i.ale;
            wrn_prev_q <= pins_i.wr_n;
            req_q      <= REQ_NONE;
            if (!pins_i.en) begin
                // Port disabled: drop any pending address.
                addr_vld_q <= 1'b0;
            end else begin
                if (wr_rise) begin
                    // Every write strobe consumes the captured address.
                    addr_vld_q <= 1'b0;
                    if (wr_accept) begin
                        req_q <= '{vld: 1'b1, addr: addr_q, data: pins_i.ad};
                    end
                end
                if (ale_fall) begin
                    addr_q     <= pins_i.ad;
                    addr_vld_q <= 1'b1;
                end
            end
        end
    end

    assign req_o = req_q;

    assert_commit_next_R3: assert property (@(posedge clk) disable iff (rst)
        (pins_i.en && wr_rise && pins_i.cs && addr_vld_q) |=> req_q.vld);

    assert_cs_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_rise && !pins_i.cs) |=> !req_q.vld);

    assert_disabled_R5: assert property (@(posedge clk) disable iff (rst)
        (!pins_i.en) |=> (!addr_vld_q && !req_q.vld));

    assert_need_addr_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_rise && !addr_vld_q) |=> !req_q.vld);

endmodule

// File: rtl/hcfg_regs.sv
module hcfg_regs
    import hcfg_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  wr_req_t                    req_i,
    output logic [NREG-1:0][BUS_W-1:0] regs_o
);

    logic [NREG-1:0][BUS_W-1:0] regs_q;
    logic [NREG-1:0]            we;
    logic                       rst_seen_q;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        assign we[i] = req_i.vld && (req_i.addr == BUS_W'(i));

        always_ff @(posedge clk) begin
            if (rst)        regs_q[i] <= '0;
            else if (we[i]) regs_q[i] <= req_i.data;
        end
    end

    always_ff @(posedge clk) rst_seen_q <= rst;

    assign regs_o = regs_q;

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst_seen_q |-> (regs_q == '0));

    assert_oob_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (req_i.vld && (int'(req_i.addr) >= NREG)) |=> $stable(regs_q));

    assert_one_target_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we));

endmodule

// File: rtl/hcfg_port.sv
module hcfg_port
    import hcfg_pkg::*;
#(
    parameter int NREG        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_en,
    input  logic                  ale,
    input  logic                  wr_n,
    input  logic                  cs,
    input  logic [BUS_W-1:0]      ad,
    output logic [NREG*BUS_W-1:0] cfg_o
);

    localparam int PINS_W = $bits(host_pins_t);

    host_pins_t                 pins_raw;
    host_pins_t                 pins_sync;
    logic [PINS_W-1:0]          pins_sync_vec;
    wr_req_t                    req;
    logic [NREG-1:0][BUS_W-1:0] regs;

    assign pins_raw = '{en: host_en, ale: ale, wr_n: wr_n, cs: cs, ad: ad};

    hcfg_sync #(
        .W       (PINS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pins_raw),
        .q_o (pins_sync_vec)
    );

    assign pins_sync = pins_sync_vec;

    hcfg_strobe u_strobe (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins_sync),
        .req_o  (req)
    );

    hcfg_regs #(
        .NREG (NREG)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req),
        .regs_o (regs)
    );

    assign cfg_o = regs;

endmodule

// File: tb/test_hcfg_port.sv
module test_hcfg_port;

    localparam int NREG = 16;
    localparam int W    = 7;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            host_en = 1'b0;
    logic            ale = 1'b0;
    logic            wr_n = 1'b1;
    logic            cs = 1'b0;
    logic [W-1:0]    ad = '0;
    logic [NREG*W-1:0] cfg_o;

    logic [W-1:0] model [NREG];
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hcfg_port #(.NREG(NREG)) i_hcfg_port (
        .clk(clk), .rst(rst), .host_en(host_en), .ale(ale),
        .wr_n(wr_n), .cs(cs), .ad(ad), .cfg_o(cfg_o)
    );

    function automatic logic [NREG*W-1:0] expect_vec();
        logic [NREG*W-1:0] v;
        for (int k = 0; k < NREG; k++) v[k*W +: W] = model[k];
        return v;
    endfunction

    task automatic check_all(input string tag);
        checks++;
        if (cfg_o !== expect_vec()) begin
            errors++;
            $display("FAIL %s: cfg_o=%h expected=%h", tag, cfg_o, expect_vec());
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic addr_phase(input logic [W-1:0] a);
        ad = a; ale = 1'b1; idle(3);
        ale = 1'b0; idle(3);
    endtask

    task automatic data_phase(input logic [W-1:0] d, input logic sel);
        ad = d; cs = sel; wr_n = 1'b0; idle(3);
        wr_n = 1'b1; idle(3);
        cs = 1'b0; idle(2);
    endtask

    task automatic host_write(input int a, input logic [W-1:0] d);
        addr_phase(W'(a));
        data_phase(d, 1'b1);
        if (a < NREG) model[a] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int k = 0; k < NREG; k++) model[k] = '0;
        idle(4);
        rst = 1'b0;
        idle(1);
        check_all("R1 reset state");

        host_en = 1'b1;
        idle(4);

        // Sweep every address, including a few past the bank (R2, R6, R8).
        for (int a = 0; a < NREG + 4; a++) begin
            host_write(a, W'((a * 37 + 5) & 127));
            check_all(a < NREG ? "R2 R8 addressed write" : "R6 out-of-range write");
        end

        // Every data value through one register (R2).
        for (int d = 0; d < 128; d++) begin
            host_write(3, W'(d));
            check_all("R2 data sweep");
        end

        // Exact latency: set wr_n high on a negedge, count edges (R3).
        addr_phase(W'(9));
        ad = 7'h55; cs = 1'b1; wr_n = 1'b0; idle(3);
        wr_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R3 not yet after third edge");
        model[9] = 7'h55;
        @(posedge clk);
        @(negedge clk);
        check_all("R3 updated at fourth edge");
        cs = 1'b0; idle(3);

        // Chip select low (R4).
        addr_phase(W'(4));
        data_phase(7'h7f, 1'b0);
        check_all("R4 cs low ignored");

        // Address consumed: second strobe with no new address (R7).
        host_write(5, 7'h11);
        data_phase(7'h22, 1'b1);
        check_all("R7 no address, no write");

        // Write strobe with no address at all after idle (R7).
        data_phase(7'h33, 1'b1);
        check_all("R7 strobe alone ignored");

        // Port disabled (R5).
        host_en = 1'b0; idle(4);
        addr_phase(W'(6));
        data_phase(7'h44, 1'b1);
        check_all("R5 disabled write ignored");

        // Address captured, then enable dropped before the data phase (R5).
        host_en = 1'b1; idle(4);
        addr_phase(W'(7));
        host_en = 1'b0; idle(4);
        host_en = 1'b1; idle(4);
        data_phase(7'h66, 1'b1);
        check_all("R5 address discarded by disable");

        // Two address strobes before one write: later wins (R9).
        addr_phase(W'(1));
        addr_phase(W'(2));
        data_phase(7'h3c, 1'b1);
        model[2] = 7'h3c;
        check_all("R9 later address used");

        // Reset again clears everything (R1).
        rst = 1'b1; idle(2);
        rst = 1'b0;
        for (int k = 0; k < NREG; k++) model[k] = '0;
        idle(1);
        check_all("R1 reset clears after writes");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule